// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel that moves data units between a memory region and a device address. A host programs a memory start address, a memory end address, a device address and a control word through a small word-indexed register port. Once started, the engine wins the bus from an external arbiter and then, for every unit, reads from the source address and writes the captured word to the destination address. After each unit it advances whichever addresses are set to increment. The run ends when the advancing memory address becomes equal to the programmed end address. There is no length counter.

One direction bit picks the roles of the address pair. In memory-to-device mode the engine reads at the memory address and writes at the device address. In the other mode it reads at the device address and writes at the memory address. A memory-to-memory copy is a memory-to-device run with hardware pacing off. Units are paced either by a software go bit or by a device request line that the control word selects. An abort stops the channel at the next unit boundary. A bus error response ends the run at once. Done and bus-error events set sticky status bits that feed a level interrupt through per-bit enables.

The bus command channel is valid/ready. Once `bus_valid` is raised, it stays high, and address, write flag, size and write data stay stable, until a cycle in which `bus_ready` is high. The responder must accept that the command is never withdrawn. Exactly one response (`bus_rvalid`) returns per accepted command, in a later cycle. The engine always accepts responses, so there is no back-pressure on them. Commands are issued only while `bus_gnt` is high.

Top module: `dma_channel`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `bus_req` and `bus_valid` are low, and the state register reads idle (0).
- R2: Register word indices are activate = 0 (bit 0), memory address = 1, memory end = 2, device address = 3, control = 4, interrupt status = 5, interrupt enable = 6, state = 7. Indices 8 to 15 read zero. In the control word only the bits under mask 0x037FFF01 are writable. Bits 1 (selected request level), 2 (done) and 5 (busy) are read-only.
- R3: With disable-hardware-flow (bit 19), go (bit 24) and activate all set, the engine runs units back to back until the memory address equals the end address. With direction bit 8 = 1 each unit reads at the memory address and writes the read data at the device address.
- R4: With bit 8 = 0 each unit reads at the device address and writes at the memory address.
- R5: The unit size is control bits 22:20 (1, 2 or 4 bytes) and is driven on `bus_size`. The memory address advances by the unit size after each unit only if bit 16 is set, and the device address only if bit 17 is set. Otherwise the address stays fixed.
- R6: With bit 19 = 0 and run (bit 0) set, units proceed only while the request line `dev_req[id]` is high, where id is control bits 15:9. Control bit 1 reads back that line's level. A request on any other line starts nothing.
- R7: On completion, done (control bit 2) and status bit 2 set, busy (bit 5) clears, and go and run clear. The state register reports idle = 0, arbitration = 1, read = 2, write = 3 and unit-end = 4 in bits 15:8.
- R8: A command is issued only while `bus_req` and `bus_gnt` are high, and it is held stable until accepted. With lock (bit 18) set, `bus_lock` is high while the channel is busy.
- R9: Setting abort (bit 25) during a run lets the current unit finish. The channel then stops with busy cleared, without done, and with the memory address reflecting the completed units. Abort, go and run clear.
- R10: An error response ends the run immediately. Status bit 0 sets, done stays clear, and the failing unit does not advance the addresses.
- R11: Writing 1 to a status bit clears it. `irq` is the OR of the status bits ANDed with the enables (index 6).
- R12: While activate is 0, a go or run setting starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dev_req | input | NUM_DEV | Device request lines |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Arbitration grant |
| bus_lock | output | 1 | Hold arbitration across units |
| bus_valid | output | 1 | Command valid |
| bus_ready | input | 1 | Command ready |
| bus_we | output | 1 | Command is a write |
| bus_addr | output | ADDR_W | Command address |
| bus_size | output | 3 | Unit size in bytes |
| bus_wdata | output | DATA_W | Write data |
| bus_rvalid | input | 1 | Response valid |
| bus_rdata | input | DATA_W | Read response data |
| bus_err | input | 1 | Response carries an error |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest case to reach from the ports is an abort that lands inside a unit, after its read is accepted and before its write response returns. That is the only case where the unit-boundary rule shows. The bench slows `bus_ready` to one cycle in three to widen the unit. It counts accepted commands and writes the abort just after the second read is accepted, so exactly two units must appear. It reaches a bus error mid-run by marking one write address as faulting in the responder, and then checks that the address register stopped one unit short.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_WAIT = 3'd4
  } dma_state_e;

  localparam int CB_RUN    = 0;
  localparam int CB_REQ    = 1;
  localparam int CB_DONE   = 2;
  localparam int CB_BUSY   = 5;
  localparam int CB_DIR    = 8;
  localparam int CB_DEV_LO = 9;
  localparam int CB_INCM   = 16;
  localparam int CB_INCD   = 17;
  localparam int CB_LOCK   = 18;
  localparam int CB_DISHW  = 19;
  localparam int CB_SZ_LO  = 20;
  localparam int CB_GO     = 24;
  localparam int CB_ABORT  = 25;

  localparam logic [31:0] CTRL_WMASK = 32'h037F_FF01;

  localparam logic [REG_IDX_W-1:0] RI_ACT   = 4'd0;
  localparam logic [REG_IDX_W-1:0] RI_MADDR = 4'd1;
  localparam logic [REG_IDX_W-1:0] RI_MEND  = 4'd2;
  localparam logic [REG_IDX_W-1:0] RI_DADDR = 4'd3;
  localparam logic [REG_IDX_W-1:0] RI_CTRL  = 4'd4;
  localparam logic [REG_IDX_W-1:0] RI_ISTS  = 4'd5;
  localparam logic [REG_IDX_W-1:0] RI_IEN   = 4'd6;
  localparam logic [REG_IDX_W-1:0] RI_FSM   = 4'd7;

  localparam int IS_BERR = 0;
  localparam int IS_DONE = 2;

  typedef struct packed {
    logic       run;
    logic       dir;
    logic       incm;
    logic       incd;
    logic       lock;
    logic       dishw;
    logic       go;
    logic       abort;
    logic [2:0] size;
    logic [6:0] dev;
  } ctl_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 hw_adv,
  input  logic [ADDR_W-1:0]    hw_mem_nxt,
  input  logic [ADDR_W-1:0]    hw_dev_nxt,
  input  logic                 hw_done,
  input  logic                 hw_berr,
  input  logic                 hw_clr,
  input  logic                 busy,
  input  dma_state_e           state,
  input  logic                 req_sel,
  output logic                 act,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [ADDR_W-1:0]    mem_end,
  output logic [ADDR_W-1:0]    dev_addr,
  output ctl_t                 ctl,
  output logic                 irq
);
  logic [31:0] ctrl_q;
  logic        done_q;
  logic [3:0]  ists_q;
  logic [3:0]  ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      mem_addr <= '0;
      mem_end  <= '0;
      dev_addr <= '0;
      ctrl_q   <= '0;
      done_q   <= 1'b0;
      ists_q   <= '0;
      ien_q    <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RI_ACT:   act      <= reg_wdata[0];
          RI_MADDR: mem_addr <= reg_wdata[ADDR_W-1:0];
          RI_MEND:  mem_end  <= reg_wdata[ADDR_W-1:0];
          RI_DADDR: dev_addr <= reg_wdata[ADDR_W-1:0];
          RI_CTRL: begin
            ctrl_q <= reg_wdata & CTRL_WMASK;
            done_q <= 1'b0;
          end
          RI_ISTS:  ists_q   <= ists_q & ~reg_wdata[3:0];
          RI_IEN:   ien_q    <= reg_wdata[3:0];
          default: ;
        endcase
      end
      // engine events take precedence over a same-cycle host write
      if (hw_adv) begin
        mem_addr <= hw_mem_nxt;
        dev_addr <= hw_dev_nxt;
      end
      if (hw_done) begin
        done_q          <= 1'b1;
        ists_q[IS_DONE] <= 1'b1;
      end
      if (hw_berr) ists_q[IS_BERR] <= 1'b1;
      if (hw_clr) begin
        ctrl_q[CB_RUN]   <= 1'b0;
        ctrl_q[CB_GO]    <= 1'b0;
        ctrl_q[CB_ABORT] <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.run   = ctrl_q[CB_RUN];
    ctl.dir   = ctrl_q[CB_DIR];
    ctl.incm  = ctrl_q[CB_INCM];
    ctl.incd  = ctrl_q[CB_INCD];
    ctl.lock  = ctrl_q[CB_LOCK];
    ctl.dishw = ctrl_q[CB_DISHW];
    ctl.go    = ctrl_q[CB_GO];
    ctl.abort = ctrl_q[CB_ABORT];
    ctl.size  = ctrl_q[CB_SZ_LO +: 3];
    ctl.dev   = ctrl_q[CB_DEV_LO +: 7];
  end

  assign irq = |(ists_q & ien_q);

  logic [31:0] ctrl_rd;
  always_comb begin
    ctrl_rd          = ctrl_q;
    ctrl_rd[CB_REQ]  = req_sel;
    ctrl_rd[CB_DONE] = done_q;
    ctrl_rd[CB_BUSY] = busy;
  end

  always_comb begin
    case (reg_addr)
      RI_ACT:   reg_rdata = {31'b0, act};
      RI_MADDR: reg_rdata = 32'(mem_addr);
      RI_MEND:  reg_rdata = 32'(mem_end);
      RI_DADDR: reg_rdata = 32'(dev_addr);
      RI_CTRL:  reg_rdata = ctrl_rd;
      RI_ISTS:  reg_rdata = {28'b0, ists_q};
      RI_IEN:   reg_rdata = {28'b0, ien_q};
      RI_FSM:   reg_rdata = {16'b0, 5'b0, state, 8'b0};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] mem_end,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              req_sel,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_lock,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              hw_adv,
  output logic [ADDR_W-1:0] hw_mem_nxt,
  output logic [ADDR_W-1:0] hw_dev_nxt,
  output logic              hw_done,
  output logic              hw_berr,
  output logic              hw_clr,
  output logic              busy,
  output dma_state_e        state
);
  logic              sent;
  logic [DATA_W-1:0] hold_q;
  logic [ADDR_W-1:0] step;
  logic              start_ok, rsp_ok, rsp_bad, in_xfer, last_unit;

  assign step       = ADDR_W'(ctl.size);
  assign hw_mem_nxt = ctl.incm ? mem_addr + step : mem_addr;
  assign hw_dev_nxt = ctl.incd ? dev_addr + step : dev_addr;
  assign start_ok   = act && !ctl.abort &&
                      (ctl.dishw ? ctl.go : (ctl.run && req_sel));
  assign in_xfer    = (state == ST_RD) || (state == ST_WR);
  assign rsp_ok     = in_xfer && sent && bus_rvalid && !bus_err;
  assign rsp_bad    = in_xfer && sent && bus_rvalid && bus_err;
  assign last_unit  = (hw_mem_nxt == mem_end);

  assign hw_adv  = (state == ST_WAIT);
  assign hw_done = (state == ST_WAIT) && last_unit;
  assign hw_berr = rsp_bad;
  assign hw_clr  = hw_done || rsp_bad ||
                   (((state == ST_IDLE) || (state == ST_WAIT)) && ctl.abort);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      sent   <= 1'b0;
      hold_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctl.abort) busy <= 1'b0;
          else if (start_ok) begin
            state <= ST_ARB;
            busy  <= 1'b1;
          end
        end
        ST_ARB: if (bus_gnt) state <= ST_RD;
        ST_RD, ST_WR: begin
          if (bus_valid && bus_ready) sent <= 1'b1;
          if (rsp_bad) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            sent  <= 1'b0;
          end else if (rsp_ok) begin
            sent <= 1'b0;
            if (state == ST_RD) begin
              hold_q <= bus_rdata;
              state  <= ST_WR;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (last_unit || ctl.abort) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            state <= ctl.dishw ? ST_ARB : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid = in_xfer && !sent;
  assign bus_we    = (state == ST_WR);
  assign bus_addr  = ((state == ST_RD) == ctl.dir) ? mem_addr : dev_addr;
  assign bus_size  = ctl.size;
  assign bus_wdata = hold_q;
  assign bus_lock  = busy && ctl.lock;
  assign bus_req   = (state == ST_ARB) || in_xfer || bus_lock;
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_DEV = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_DEV-1:0]   dev_req,
  output logic                 bus_req,
  input  logic                 bus_gnt,
  output logic                 bus_lock,
  output logic                 bus_valid,
  input  logic                 bus_ready,
  output logic                 bus_we,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [2:0]           bus_size,
  output logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rvalid,
  input  logic [DATA_W-1:0]    bus_rdata,
  input  logic                 bus_err,
  output logic                 irq
);
  ctl_t              ctl;
  logic              act, req_sel, busy;
  logic              hw_adv, hw_done, hw_berr, hw_clr;
  logic [ADDR_W-1:0] mem_addr, mem_end, dev_addr, hw_mem_nxt, hw_dev_nxt;
  dma_state_e        state;

  always_comb begin
    req_sel = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (ctl.dev == 7'(i)) req_sel = dev_req[i];
  end

  dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_adv(hw_adv),
    .hw_mem_nxt(hw_mem_nxt), .hw_dev_nxt(hw_dev_nxt), .hw_done(hw_done),
    .hw_berr(hw_berr), .hw_clr(hw_clr), .busy(busy), .state(state),
    .req_sel(req_sel), .act(act), .mem_addr(mem_addr), .mem_end(mem_end),
    .dev_addr(dev_addr), .ctl(ctl), .irq(irq)
  );

  dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .act(act), .ctl(ctl), .mem_addr(mem_addr),
    .mem_end(mem_end), .dev_addr(dev_addr), .req_sel(req_sel),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .hw_adv(hw_adv), .hw_mem_nxt(hw_mem_nxt), .hw_dev_nxt(hw_dev_nxt),
    .hw_done(hw_done), .hw_berr(hw_berr), .hw_clr(hw_clr), .busy(busy),
    .state(state)
  );
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic [3:0]        reg_addr,
  input logic [31:0]       reg_rdata
);
  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

  assert_cmd_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_req && bus_gnt));

  assert_err_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && bus_err) |=> !bus_valid);

  assert_state_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd7) |-> (reg_rdata[15:8] <= 8'd4 && reg_rdata[31:16] == 16'd0
                            && reg_rdata[7:0] == 8'd0));
endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_dma_channel.sv
`timescale 1ns/1ps
module sim_dma_channel;
  localparam int NDEV = 16;
  localparam logic [31:0] C_RUN = 32'h1, C_DIR = 32'h100, C_INCM = 32'h1_0000,
    C_INCD = 32'h2_0000, C_LOCK = 32'h4_0000, C_DISHW = 32'h8_0000,
    C_SZ1 = 32'h10_0000, C_SZ2 = 32'h20_0000, C_SZ4 = 32'h40_0000,
    C_GO = 32'h100_0000, C_ABORT = 32'h200_0000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NDEV-1:0] dev_req = 0;
  logic bus_req, bus_gnt, bus_lock, bus_valid, bus_ready, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0] bus_size;
  logic bus_rvalid, bus_err, irq;

  int tests = 0, fails = 0, cyc = 0, hs = 0, nwr = 0;
  bit slow = 0, finished = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] q_addr[$], q_data[$];
  bit q_we[$];

  always #2.5 clk = ~clk;

  dma_channel #(.NUM_DEV(NDEV)) u0 (.*);

  function automatic logic [31:0] rdfn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // bus responder: grant follows request, response two cycles after accept
  logic pend; int lat; logic p_err; logic [31:0] p_data;
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 0; bus_ready <= 0; bus_rvalid <= 0; bus_err <= 0; bus_rdata <= 0;
      pend <= 0; lat <= 0; p_err <= 0; p_data <= 0;
    end else begin
      bus_gnt <= bus_req;
      bus_ready <= slow ? (cyc % 3 == 0) : 1'b1;
      bus_rvalid <= 0; bus_err <= 0;
      if (bus_valid && bus_ready) begin
        pend <= 1; lat <= 2; p_err <= (bus_addr == err_addr); p_data <= rdfn(bus_addr);
      end else if (pend) begin
        if (lat == 1) begin
          bus_rvalid <= 1; bus_err <= p_err; bus_rdata <= p_data; pend <= 0;
        end
        lat <= lat - 1;
      end
    end
  end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model of bus traffic, compared every clock
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready) begin
      hs++;
      if (bus_we) nwr++;
      if (q_addr.size() == 0) chk("R8 unexpected command", bus_addr, 32'hDEAD_DEAD);
      else begin
        chk("R3/R4 command kind", {31'b0, bus_we}, {31'b0, q_we[0]});
        chk("R3/R4/R5 command address", bus_addr, q_addr[0]);
        if (q_we[0]) chk("R3 write data", bus_wdata, q_data[0]);
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_we.pop_front());
      end
    end
  end

  task automatic unit(input logic [31:0] ra, input logic [31:0] wa);
    q_we.push_back(0); q_addr.push_back(ra); q_data.push_back(0);
    q_we.push_back(1); q_addr.push_back(wa); q_data.push_back(rdfn(ra));
  endtask

  task automatic wreg(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = i; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rreg(input logic [3:0] i, output logic [31:0] v);
    reg_addr = i; #0.1; v = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] m, input logic [31:0] e, input logic [31:0] d,
                       input logic [31:0] ien, input logic [31:0] c);
    wreg(6, ien); wreg(1, m); wreg(2, e); wreg(3, d); wreg(0, 1); wreg(4, c);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5000; k++) begin
      rreg(4, v);
      if (!v[5]) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    logic [31:0] v;
    int base_wr;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin rreg(4'(i), v); chk("R1 reset register", v, 0); end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 bus idle", {30'b0, bus_req, bus_valid}, 0);

    // R2 register map and writable mask
    wreg(1, 32'h1234_5678); wreg(2, 32'h0000_ABCD); wreg(3, 32'hCAFE_0000);
    rreg(1, v); chk("R2 memory address", v, 32'h1234_5678);
    rreg(2, v); chk("R2 memory end", v, 32'h0000_ABCD);
    rreg(3, v); chk("R2 device address", v, 32'hCAFE_0000);
    wreg(4, 32'h00FF_FF01);
    rreg(4, v); chk("R2 control mask", v, 32'h007F_FF01);
    wreg(6, 32'hF); rreg(6, v); chk("R2 enables", v, 32'hF);
    rreg(9, v); chk("R2 unused index", v, 0);
    // R12 activate low blocks go
    wreg(4, C_DISHW | C_GO);
    repeat (20) @(negedge clk);
    chk("R12 no request while inactive", {31'b0, bus_req}, 0);
    rreg(4, v); chk("R12 not busy", {31'b0, v[5]}, 0);
    wreg(4, 0);

    // R3 R5 R7 R8 R11 memory-to-device, 4-byte units, both increment
    for (int i = 0; i < 4; i++) unit(32'h1000 + 4 * i, 32'h8000 + 4 * i);
    setup(32'h1000, 32'h1010, 32'h8000, 32'h4,
          C_DIR | C_INCM | C_INCD | C_LOCK | C_DISHW | C_SZ4 | C_GO);
    repeat (3) @(negedge clk);
    chk("R8 lock held while busy", {31'b0, bus_lock}, 1);
    chk("R5 size on bus", {29'b0, bus_size}, 3'd4);
    wait_idle();
    chk("R3 all commands seen", q_addr.size(), 0);
    rreg(1, v); chk("R3 memory address at end", v, 32'h1010);
    rreg(3, v); chk("R5 device advanced", v, 32'h8010);
    rreg(4, v); chk("R7 control after done", v, C_DIR | C_INCM | C_INCD | C_LOCK | C_DISHW | C_SZ4 | 32'h4);
    rreg(5, v); chk("R7 done status", v, 32'h4);
    rreg(7, v); chk("R7 idle state", v, 0);
    chk("R11 irq on done", {31'b0, irq}, 1);
    chk("R8 lock released", {31'b0, bus_lock}, 0);
    wreg(5, 32'h4);
    rreg(5, v); chk("R11 write one clears", v, 0);
    chk("R11 irq cleared", {31'b0, irq}, 0);

    // R4 R5 device-to-memory, 2-byte, device fixed
    for (int i = 0; i < 3; i++) unit(32'h9000, 32'h2000 + 2 * i);
    setup(32'h2000, 32'h2006, 32'h9000, 32'h0, C_INCM | C_DISHW | C_SZ2 | C_GO);
    wait_idle();
    chk("R4 all commands seen", q_addr.size(), 0);
    rreg(1, v); chk("R4 memory address at end", v, 32'h2006);
    rreg(3, v); chk("R5 fixed device address", v, 32'h9000);

    // R5 byte units
    for (int i = 0; i < 2; i++) unit(32'h3001 + i, 32'h9100);
    setup(32'h3001, 32'h3003, 32'h9100, 32'h0, C_DIR | C_INCM | C_DISHW | C_SZ1 | C_GO);
    wait_idle();
    chk("R5 byte units seen", q_addr.size(), 0);
    rreg(1, v); chk("R5 byte step", v, 32'h3003);

    // R6 hardware pacing on line 3
    setup(32'h4000, 32'h4008, 32'h9200, 32'h0,
          C_DIR | C_INCM | C_INCD | (32'd3 << 9) | C_SZ4 | C_RUN);
    dev_req = 16'h0004;
    repeat (20) @(negedge clk);
    chk("R6 other line ignored", {31'b0, bus_req}, 0);
    rreg(4, v); chk("R6 request bit low", {31'b0, v[1]}, 0);
    for (int i = 0; i < 2; i++) unit(32'h4000 + 4 * i, 32'h9200 + 4 * i);
    dev_req = 16'h0008;
    rreg(4, v); chk("R6 request bit high", {31'b0, v[1]}, 1);
    wait_idle();
    chk("R6 paced units seen", q_addr.size(), 0);
    rreg(4, v); chk("R7 run cleared", v, C_DIR | C_INCM | C_INCD | (32'd3 << 9) | C_SZ4 | 32'h6);
    dev_req = 0;

    // R9 abort mid-unit, R7 state codes
    wreg(5, 32'hF);
    slow = 1;
    for (int i = 0; i < 10; i++) unit(32'h5000 + 4 * i, 32'h9300 + 4 * i);
    base_wr = nwr;
    setup(32'h5000, 32'h5028, 32'h9300, 32'h0, C_DIR | C_INCM | C_INCD | C_DISHW | C_SZ4 | C_GO);
    while (!(bus_valid && !bus_we)) @(negedge clk);
    rreg(7, v); chk("R7 read state code", v, 32'h200);
    while (!(bus_valid && bus_we)) @(negedge clk);
    rreg(7, v); chk("R7 write state code", v, 32'h300);
    while (hs < 3 + (hs - (hs % 1)) - hs + hs && (nwr - base_wr) < 1) @(negedge clk);
    while (!(bus_valid && !bus_we)) @(negedge clk);
    wreg(4, C_DIR | C_INCM | C_INCD | C_DISHW | C_SZ4 | C_GO | C_ABORT);
    wait_idle();
    q_addr.delete(); q_data.delete(); q_we.delete();
    chk("R9 units before stop", nwr - base_wr, 2);
    rreg(1, v); chk("R9 memory address after abort", v, 32'h5008);
    rreg(5, v); chk("R9 no done status", v, 0);
    rreg(4, v); chk("R9 control after abort", v, C_DIR | C_INCM | C_INCD | C_DISHW | C_SZ4);
    slow = 0;

    // R10 bus error on second write
    err_addr = 32'hA004;
    unit(32'h6000, 32'hA000); unit(32'h6004, 32'hA004);
    setup(32'h6000, 32'h6010, 32'hA000, 32'h1, C_DIR | C_INCM | C_INCD | C_DISHW | C_SZ4 | C_GO);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R10 no commands after error", q_addr.size(), 0);
    rreg(5, v); chk("R10 error status", v, 32'h1);
    rreg(1, v); chk("R10 address not advanced", v, 32'h6004);
    rreg(4, v); chk("R10 no done, go cleared", v, C_DIR | C_INCM | C_INCD | C_DISHW | C_SZ4);
    chk("R11 irq on error", {31'b0, irq}, 1);
    wreg(5, 32'h1);
    chk("R11 irq cleared after error", {31'b0, irq}, 0);
    err_addr = 32'hFFFF_FFFF;

    summary();
  end
endmodule